// File: doc/BRIEF.md
# Power-of-two transfer chunking controller

This block turns one long flash read or write request into a series of short transactions for a downstream phase sequencer. Each transaction moves 1, 2, 4 or 8 bytes. The block picks the size of each chunk, builds the phase enables and the data byte mask for it, decides whether chip select stays asserted afterwards, and advances the address and the buffer offset. It then starts the sequencer and waits for that transaction to finish.

A write sends the command and the address only in its first chunk. Later chunks carry data alone, and chip select is held between chunks. A read repeats the command and address in every chunk, with the address moved forward by the bytes already read. A request with no data, or with length zero, becomes one transaction carrying only the base phases. If a transaction does not report completion within a programmable number of cycles, the block pulses an engine reset, flags an error and drops the request.

The controller is a five-state machine:
- IDLE: waits for a request.
- ISSUE: pulses `txn_start` with the chunk fields.
- WAIT: waits for `txn_done` while a timeout counter runs.
- DONE: pulses `req_done`.
- ABORT: pulses `engine_reset` and `req_error`.

The transitions are:
- IDLE to ISSUE when `req_valid` is seen.
- ISSUE to WAIT always.
- WAIT to ISSUE on `txn_done` when bytes remain.
- WAIT to DONE on `txn_done` for the last chunk.
- WAIT to ABORT when the timeout expires.
- DONE to IDLE and ABORT to IDLE always.

Top module: `flash_chunk_ctrl`

## Requirements
- R1: The size of each chunk (`txn_size`, which holds the byte count 1, 2, 4 or 8) is the largest allowed size that does not exceed the bytes still to move.
- R2: The largest chunk is 4 bytes when `bus_wide` is 0 and 8 bytes when `bus_wide` is 1. `bus_wide` is sampled when the request is accepted.
- R3: `txn_data_mask[3:0]` has its upper k bits set (k=1 gives 1000, k=2 gives 1100, k=4 gives 1111). k is the chunk byte count, halved when `bus_wide` is 1, then limited to the range 1 to 4.
- R4: In a write, the first chunk carries `req_cmd_en` and `req_addr_mask`. Every later chunk drives `txn_cmd_en`=0 and `txn_addr_mask`=0000.
- R5: `txn_keep_sel` is 1 on every write chunk except the last. It is always 0 on reads and on requests with no data.
- R6: `txn_buf_offset` equals the bytes already moved. On reads, `txn_addr` equals `req_addr` plus that count and the command and address enables repeat in every chunk. On writes, `txn_addr` stays `req_addr`.
- R7: If `txn_done` does not arrive within TIMEOUT_CYCLES cycles of WAIT, then `engine_reset` and `req_error` pulse together for one cycle, `busy` drops, and no further transaction starts.
- R8: A request with `req_data_en`=0 or `req_len`=0 issues exactly one transaction with `txn_size`=0, `txn_data_mask`=0000 and `txn_keep_sel`=0, and then completes.
- R9: `busy` is 1 from the cycle after acceptance until the last chunk completes. `req_done` then pulses for one cycle with `busy` at 0. After reset, `busy`, `txn_start`, `req_done` and `req_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_data_en | input | 1 | The request has a data phase |
| req_cmd_en | input | 1 | The request has a command phase |
| req_addr_mask | input | 4 | Address byte enable mask |
| req_addr | input | AW | Start address |
| req_len | input | LW | Total byte count |
| bus_wide | input | 1 | 1 = 16-bit flash bus, 0 = 8-bit |
| txn_done | input | 1 | Sequencer finished the current transaction |
| txn_start | output | 1 | Start pulse for one transaction |
| txn_write | output | 1 | Direction of the transaction |
| txn_cmd_en | output | 1 | Command phase enable for this chunk |
| txn_addr_mask | output | 4 | Address byte mask for this chunk |
| txn_data_mask | output | 4 | Data byte mask for this chunk |
| txn_keep_sel | output | 1 | Keep chip select asserted after this chunk |
| txn_size | output | 4 | Chunk byte count (0, 1, 2, 4 or 8) |
| txn_addr | output | AW | Flash address for this chunk |
| txn_buf_offset | output | LW | Buffer offset of this chunk |
| engine_reset | output | 1 | Reset pulse to the sequencer on timeout |
| busy | output | 1 | A request is in progress |
| req_done | output | 1 | Request completed |
| req_error | output | 1 | Request aborted by timeout |

## Verification
The bench goes after remainders that are not powers of two, such as 7, 13 and 11 bytes. A sizer that rounded up instead of down would overrun the buffer, and one that ignored the bus width would issue 8-byte chunks on a narrow bus. On a wide bus, single-byte chunks are the clamp corner: if the halved count were not raised back to 1, the data mask would be empty. Writes are checked for command and address enables leaking into later chunks and for a keep-select left set on the last chunk, which would leave chip select stuck. Reads are checked for an address that fails to advance. The bench also runs zero-length requests and a transaction that never completes; a broken timeout would hang the request or abort one that finishes in time.

// File: rtl/flash_chunk_pkg.sv
package flash_chunk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_ABORT
    } chunk_state_e;

    // Byte-lane mask: the top k bits are set, where k is the byte count
    // (halved on a wide bus), limited to the range 1..4.
    function automatic logic [3:0] lane_mask(input logic [3:0] nbytes, input logic wide);
        logic [3:0] k;
        k = wide ? (nbytes >> 1) : nbytes;
        if (k == 4'd0) k = 4'd1;
        if (k > 4'd4)  k = 4'd4;
        unique case (k)
            4'd1:    return 4'b1000;
            4'd2:    return 4'b1100;
            4'd3:    return 4'b1110;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
    parameter int LW = 16
) (
    input  logic [LW-1:0] remaining,
    input  logic          wide,
    output logic [3:0]    size,
    output logic [3:0]    mask
);
    import flash_chunk_pkg::*;

    localparam logic [LW-1:0] R8 = LW'(8);
    localparam logic [LW-1:0] R4 = LW'(4);
    localparam logic [LW-1:0] R2 = LW'(2);
    localparam logic [LW-1:0] R1 = LW'(1);

    always_comb begin
        if (wide && remaining >= R8)  size = 4'd8;
        else if (remaining >= R4)     size = 4'd4;
        else if (remaining >= R2)     size = 4'd2;
        else if (remaining >= R1)     size = 4'd1;
        else                          size = 4'd0;
        mask = lane_mask(size, wide);
    end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int LIMIT = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/flash_chunk_ctrl.sv
module flash_chunk_ctrl #(
    parameter int AW             = 32,
    parameter int LW             = 16,
    parameter int TIMEOUT_CYCLES = 100_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_data_en,
    input  logic          req_cmd_en,
    input  logic [3:0]    req_addr_mask,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          bus_wide,
    input  logic          txn_done,
    output logic          txn_start,
    output logic          txn_write,
    output logic          txn_cmd_en,
    output logic [3:0]    txn_addr_mask,
    output logic [3:0]    txn_data_mask,
    output logic          txn_keep_sel,
    output logic [3:0]    txn_size,
    output logic [AW-1:0] txn_addr,
    output logic [LW-1:0] txn_buf_offset,
    output logic          engine_reset,
    output logic          busy,
    output logic          req_done,
    output logic          req_error
);
    import flash_chunk_pkg::*;

    chunk_state_e state, state_nx;

    logic          write_q, nodata_q, cmd_q, wide_q, first_q;
    logic [3:0]    amask_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q, pos_q;
    logic [3:0]    sz_raw, mask_raw;
    logic          expired, last_chunk;

    chunk_sizer #(.LW(LW)) u_sizer (
        .remaining (rem_q),
        .wide      (wide_q),
        .size      (sz_raw),
        .mask      (mask_raw)
    );

    wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    assign last_chunk = nodata_q || (rem_q == LW'(sz_raw));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (txn_done)     state_nx = last_chunk ? ST_DONE : ST_ISSUE;
                else if (expired) state_nx = ST_ABORT;
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // request and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            nodata_q <= 1'b1;
            cmd_q    <= 1'b0;
            wide_q   <= 1'b0;
            first_q  <= 1'b1;
            amask_q  <= '0;
            addr_q   <= '0;
            rem_q    <= '0;
            pos_q    <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            write_q  <= req_write;
            nodata_q <= !req_data_en || (req_len == '0);
            cmd_q    <= req_cmd_en;
            wide_q   <= bus_wide;
            first_q  <= 1'b1;
            amask_q  <= req_addr_mask;
            addr_q   <= req_addr;
            rem_q    <= req_len;
            pos_q    <= '0;
        end else if (state == ST_WAIT && txn_done) begin
            first_q  <= 1'b0;
            rem_q    <= rem_q - LW'(sz_raw);
            pos_q    <= pos_q + LW'(sz_raw);
        end
    end

    // outputs
    always_comb begin
        txn_start      = (state == ST_ISSUE);
        busy           = (state == ST_ISSUE) || (state == ST_WAIT);
        req_done       = (state == ST_DONE);
        req_error      = (state == ST_ABORT);
        engine_reset   = (state == ST_ABORT);
        txn_write      = write_q;
        txn_size       = nodata_q ? 4'd0 : sz_raw;
        txn_data_mask  = nodata_q ? 4'b0000 : mask_raw;
        txn_keep_sel   = write_q && !nodata_q && (rem_q > LW'(sz_raw));
        txn_cmd_en     = (write_q && !first_q) ? 1'b0 : cmd_q;
        txn_addr_mask  = (write_q && !first_q) ? 4'b0000 : amask_q;
        txn_addr       = write_q ? addr_q : (addr_q + AW'(pos_q));
        txn_buf_offset = pos_q;
    end

    AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !nodata_q) |-> $onehot(txn_size));                       // R1
    AST_SIZE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !nodata_q) |-> (LW'(txn_size) <= rem_q));                 // R1
    AST_NARROW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !wide_q) |-> (txn_size <= 4'd4));                         // R2
    AST_LATER_WRITE_BARE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && write_q && pos_q != '0) |-> (!txn_cmd_en && txn_addr_mask == 4'b0000)); // R4
    AST_READ_NO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !write_q) |-> !txn_keep_sel);                             // R5
    AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !txn_done && expired) |=> (req_error && engine_reset && !busy)); // R7
    AST_DONE_AFTER_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(txn_done));                                          // R9

endmodule

// File: tb/flash_chunk_ctrl_bench.sv
module flash_chunk_ctrl_bench;

    localparam int AW  = 32;
    localparam int LW  = 16;
    localparam int TMO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_data_en = 1'b0, req_cmd_en = 1'b0;
    logic [3:0]    req_addr_mask = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          bus_wide = 1'b0, txn_done = 1'b0;
    logic          txn_start, txn_write, txn_cmd_en, txn_keep_sel;
    logic [3:0]    txn_addr_mask, txn_data_mask, txn_size;
    logic [AW-1:0] txn_addr;
    logic [LW-1:0] txn_buf_offset;
    logic          engine_reset, busy, req_done, req_error;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    flash_chunk_ctrl #(.AW(AW), .LW(LW), .TIMEOUT_CYCLES(TMO)) u_flash_chunk_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_data_en(req_data_en), .req_cmd_en(req_cmd_en), .req_addr_mask(req_addr_mask),
        .req_addr(req_addr), .req_len(req_len), .bus_wide(bus_wide), .txn_done(txn_done),
        .txn_start(txn_start), .txn_write(txn_write), .txn_cmd_en(txn_cmd_en),
        .txn_addr_mask(txn_addr_mask), .txn_data_mask(txn_data_mask),
        .txn_keep_sel(txn_keep_sel), .txn_size(txn_size), .txn_addr(txn_addr),
        .txn_buf_offset(txn_buf_offset), .engine_reset(engine_reset), .busy(busy),
        .req_done(req_done), .req_error(req_error));

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_size(input int rem, input bit wide);
        if (wide && rem >= 8) return 8;
        if (rem >= 4) return 4;
        if (rem >= 2) return 2;
        if (rem >= 1) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] exp_mask(input int n, input bit wide);
        int k;
        k = wide ? n / 2 : n;
        if (k < 1) k = 1;
        if (k > 4) k = 4;
        return 4'(4'hF << (4 - k));
    endfunction

    task automatic run_req(input bit wr, input bit de, input bit ce, input logic [3:0] am,
                           input logic [31:0] ad, input int len, input bit wd, input bit rnd_dly);
        int rem, pos, sz, dly;
        bit nodata, first, last;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_data_en = de; req_cmd_en = ce;
        req_addr_mask = am; req_addr = ad; req_len = LW'(len); bus_wide = wd;
        @(negedge clk);
        req_valid = 1'b0;
        bus_wide = ~wd;
        rem = len; pos = 0; first = 1'b1;
        nodata = !de || (len == 0);
        for (int it = 0; it < 64; it++) begin
            chk(txn_start == 1'b1, "R9 start", txn_start, 1);
            chk(busy == 1'b1, "R9 busy", busy, 1);
            sz = nodata ? 0 : exp_size(rem, wd);
            chk(txn_size == 4'(sz), nodata ? "R8 size" : (wd ? "R2 size" : "R1 size"), txn_size, sz);
            chk(txn_data_mask == (nodata ? 4'b0 : exp_mask(sz, wd)), nodata ? "R8 mask" : "R3 mask",
                txn_data_mask, nodata ? 4'b0 : exp_mask(sz, wd));
            chk(txn_keep_sel == (wr && !nodata && rem > sz), nodata ? "R8 keep" : "R5 keep",
                txn_keep_sel, (wr && !nodata && rem > sz));
            if (wr && !first)
                chk({txn_cmd_en, txn_addr_mask} == 5'b0, "R4 later bare", {txn_cmd_en, txn_addr_mask}, 0);
            else
                chk({txn_cmd_en, txn_addr_mask} == {ce, am}, "R4 phases", {txn_cmd_en, txn_addr_mask}, {ce, am});
            chk(txn_addr == (wr ? ad : ad + 32'(pos)), "R6 addr", txn_addr, wr ? ad : ad + 32'(pos));
            chk(txn_buf_offset == LW'(pos), "R6 offset", txn_buf_offset, pos);
            @(negedge clk);
            dly = rnd_dly ? int'($urandom_range(0, 3)) : 0;
            for (int d = 0; d < dly; d++) @(negedge clk);
            txn_done = 1'b1;
            @(negedge clk);
            txn_done = 1'b0;
            last = nodata || (rem == sz);
            rem -= sz; pos += sz; first = 1'b0;
            if (last) begin
                chk(req_done == 1'b1 && busy == 1'b0 && txn_start == 1'b0, nodata ? "R8 done" : "R9 done",
                    {req_done, busy, txn_start}, 3'b100);
                return;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        chk({busy, txn_start, req_done, req_error} == 4'b0, "R9 reset", {busy, txn_start, req_done, req_error}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_req(1'b1, 1'b1, 1'b1, 4'b0111, 32'h0000_1000, 7, 1'b0, 1'b0);   // write 4,2,1
        run_req(1'b1, 1'b1, 1'b1, 4'b1111, 32'h0020_0000, 13, 1'b1, 1'b0);  // write 8,4,1 wide
        run_req(1'b0, 1'b1, 1'b1, 4'b0111, 32'h0000_3000, 11, 1'b0, 1'b1);  // read 4,4,2,1
        run_req(1'b0, 1'b1, 1'b1, 4'b1111, 32'h0000_0040, 3, 1'b1, 1'b0);   // wide 2,1 clamp
        run_req(1'b0, 1'b1, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b0);           // zero length
        run_req(1'b1, 1'b0, 1'b1, 4'b0000, 32'h0, 9, 1'b1, 1'b0);           // no data phase

        for (int n = 0; n < 30; n++)
            run_req(1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)),
                    4'($urandom_range(0, 15)), $urandom, int'($urandom_range(0, 40)),
                    1'($urandom_range(0, 1)), 1'b1);

        // R7 timeout: no done ever
        begin
            int waited;
            bit seen;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_data_en = 1'b1; req_cmd_en = 1'b1;
            req_addr_mask = 4'b0111; req_len = LW'(8); bus_wide = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
            waited = 0; seen = 1'b0;
            for (int i = 0; i < TMO + 10 && !seen; i++) begin
                @(negedge clk);
                waited++;
                if (req_error) seen = 1'b1;
            end
            chk(seen && waited >= TMO && waited <= TMO + 3, "R7 timeout window", waited, TMO + 1);
            chk(engine_reset == 1'b1 && busy == 1'b0, "R7 reset pulse", {engine_reset, busy}, 2'b10);
            @(negedge clk);
            chk({txn_start, req_error, busy} == 3'b0, "R7 no further txn", {txn_start, req_error, busy}, 0);
        end

        run_req(1'b0, 1'b1, 1'b1, 4'b0111, 32'h0000_0100, 5, 1'b0, 1'b0);    // recovery after abort
        finish_run();
    end

endmodule